// File: doc/BRIEF.md
# Dword Bus Byte-Lane Steering and Split Unit

This unit sits between a core's load/store port and an external data bus that is a fixed number of byte lanes wide (four by default) and can only address lane-aligned words. For each accepted access of 1, 2 or 4 bytes it drives an aligned bus address, a set of active-low per-lane enables, and write data moved onto the lanes that the byte offset selects. The core hands over one request and waits for a completion pulse.

An access whose bytes run past the end of the aligned word is carried out as two bus cycles in sequence: the aligned word first, the next word second. For reads, the enabled lanes of both cycles are combined and moved back down so that the first byte of the access lands in bits [7:0] of the result. When the alignment-check input is high, an access whose address is not a multiple of its size is refused with a one-cycle fault pulse and never reaches the bus. Every bus cycle waits for a ready response before the next one starts.

Top module: `lane_split_unit`

## Requirements
- R1: Every bus cycle drives an address whose two low bits are zero; the first cycle of an access uses the request address with its low two bits cleared, and a second cycle uses that address plus 4.
- R2: `bus_be_n` has one active-low enable per lane; enable bit k (k = 0..3) selects data bits [8k+7:8k], so byte offset 0 uses bit 0 and lanes [7:0], byte offset 3 uses bit 3 and lanes [31:24]. At least one enable is low in every bus cycle.
- R3: `req_size` encodes the access length: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes; code 3 is not used. The enabled lanes are offset, offset+1, ... for that many bytes, taken modulo 4 across the cycles.
- R4: An access splits into two bus cycles exactly when offset + length > 4: the first cycle enables lanes offset..3 and the second enables lanes 0..offset+length-5. A 1-byte access never splits; a 2-byte access splits only at offset 3.
- R5: On writes, byte k of `req_wdata` appears on lane (offset + k) mod 4 in whichever cycle enables that lane; lanes not enabled in a cycle carry zero.
- R6: On reads, byte k of `rdata` (k below the length) is taken from lane (offset + k) mod 4 of the cycle that enabled that lane; bytes at or above the length read as zero, and bus data on lanes not enabled, or while `bus_ready` is low, is ignored.
- R7: A bus cycle holds its address, enables and data until `bus_ready` is sampled high; `done` is high for exactly one cycle, the cycle after the final bus cycle's ready, and never after the first cycle of a split access.
- R8: With `align_chk_en` high, a request whose address is not a multiple of its length produces a one-cycle `align_fault` in the cycle after the request, with no bus cycle and no `done`; with it low, such a request is performed normally.
- R9: After reset `bus_valid`, `busy`, `done` and `align_fault` are low and `bus_be_n` is all ones.
- R10: A request is accepted only while `busy` is low; `busy` stays high from acceptance until `done`, and `req_valid` raised while busy is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe, sampled while not busy |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Length code: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| req_addr | input | AW (32) | Byte address of the access |
| req_wdata | input | 32 | Store data, first byte in bits [7:0] |
| align_chk_en | input | 1 | Refuse misaligned accesses with a fault |
| busy | output | 1 | An accepted access is in progress |
| done | output | 1 | One-cycle completion pulse |
| align_fault | output | 1 | One-cycle misalignment fault pulse |
| rdata | output | 32 | Load result, first byte in bits [7:0], updated with `done` on loads |
| bus_valid | output | 1 | A bus cycle is in progress |
| bus_write | output | 1 | Direction of the bus cycle |
| bus_addr | output | AW (32) | Aligned bus address |
| bus_be_n | output | 4 | Active-low lane enables |
| bus_wdata | output | 32 | Lane-steered store data |
| bus_rdata | input | 32 | Bus read data, sampled with `bus_ready` |
| bus_ready | input | 1 | Bus cycle completes at this edge |

## Verification
The properties assume the core never presents size code 3 and that the bus raises `bus_ready` only while `bus_valid` is high; the bench drives ready solely inside an open bus cycle and draws sizes from 0 to 2. They also take for granted that the core waits for `done` or `align_fault` before relying on a new request being taken, so the one deliberate request issued while busy checks that it is dropped rather than queued. The bus model answers each cycle after a chosen number of wait states with a word whose lanes all differ and are all non-zero, so a wrongly enabled or wrongly rotated lane shows up in the result.

// File: rtl/dwbus_pkg.sv
package dwbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

endpackage

// File: rtl/lane_planner.sv
module lane_planner #(
  parameter int NLANES = 4,
  localparam int OFFW = $clog2(NLANES),
  localparam int SZW  = $clog2(OFFW + 1)
) (
  input  logic [OFFW-1:0]   offset,
  input  logic [SZW-1:0]    size,
  output logic [NLANES-1:0] first_mask,
  output logic [NLANES-1:0] second_mask,
  output logic              crosses,
  output logic              misaligned
);
  logic [NLANES-1:0]   base_mask;
  logic [2*NLANES-1:0] wide_mask;
  logic [OFFW-1:0]     size_low;

  // lanes 0..len-1 before shifting by the byte offset
  for (genvar i = 0; i < NLANES; i++) begin : g_base
    assign base_mask[i] = (32'(i) < (32'd1 << size));
  end

  // low offset bits that must be zero for natural alignment
  for (genvar b = 0; b < OFFW; b++) begin : g_low
    assign size_low[b] = (SZW'(b) < size);
  end

  assign wide_mask   = {{NLANES{1'b0}}, base_mask} << offset;
  assign first_mask  = wide_mask[NLANES-1:0];
  assign second_mask = wide_mask[2*NLANES-1:NLANES];
  assign crosses     = |second_mask;
  assign misaligned  = |(offset & size_low);
endmodule

// File: rtl/byte_rotator.sv
module byte_rotator #(
  parameter int NLANES = 4,
  parameter bit LEFT   = 1'b1,
  localparam int OFFW = $clog2(NLANES),
  localparam int DW   = 8 * NLANES
) (
  input  logic [DW-1:0]   din,
  input  logic [OFFW-1:0] amt,
  output logic [DW-1:0]   dout
);
  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    localparam logic [OFFW-1:0] JL = OFFW'(j);
    logic [OFFW-1:0] src;
    if (LEFT) begin : g_left
      assign src = JL - amt;
    end else begin : g_right
      assign src = JL + amt;
    end
    assign dout[8*j +: 8] = din[8*src +: 8];
  end
endmodule

// File: rtl/lane_gate.sv
module lane_gate #(
  parameter int NLANES = 4,
  localparam int DW = 8 * NLANES
) (
  input  logic [DW-1:0]     din,
  input  logic [NLANES-1:0] keep,
  output logic [DW-1:0]     dout
);
  for (genvar j = 0; j < NLANES; j++) begin : g_lane
    assign dout[8*j +: 8] = keep[j] ? din[8*j +: 8] : 8'h00;
  end
endmodule

// File: rtl/lane_split_unit.sv
module lane_split_unit
  import dwbus_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NLANES = 4,
  localparam int OFFW = $clog2(NLANES),
  localparam int SZW  = $clog2(OFFW + 1),
  localparam int DW   = 8 * NLANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [SZW-1:0]    req_size,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              align_chk_en,
  output logic              busy,
  output logic              done,
  output logic              align_fault,
  output logic [DW-1:0]     rdata,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [AW-1:0]     bus_addr,
  output logic [NLANES-1:0] bus_be_n,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  input  logic              bus_ready
);
  localparam logic [AW-1:0] WORD_STEP = AW'(NLANES);

  seq_state_e        state_q;
  logic              write_q;
  logic [OFFW-1:0]   off_q;
  logic [NLANES-1:0] m1_q, m2_q;
  logic              split_q;
  logic [DW-1:0]     rot_wdata_q;
  logic [DW-1:0]     lane_buf_q;

  logic              bus_valid_q, bus_write_q, done_q, fault_q;
  logic [AW-1:0]     bus_addr_q;
  logic [NLANES-1:0] bus_be_n_q;
  logic [DW-1:0]     bus_wdata_q, rdata_q;

  // request decode
  logic [OFFW-1:0]   req_off;
  logic [NLANES-1:0] plan_m1, plan_m2;
  logic              plan_cross, plan_misal;
  logic [DW-1:0]     rot_now;

  assign req_off = req_addr[OFFW-1:0];

  lane_planner #(.NLANES(NLANES)) u_plan (
    .offset     (req_off),
    .size       (req_size),
    .first_mask (plan_m1),
    .second_mask(plan_m2),
    .crosses    (plan_cross),
    .misaligned (plan_misal)
  );

  byte_rotator #(.NLANES(NLANES), .LEFT(1'b1)) u_wrot (
    .din (req_wdata),
    .amt (req_off),
    .dout(rot_now)
  );

  // lane-gated store data for the cycle about to be launched
  logic [NLANES-1:0] cyc_mask;
  logic [DW-1:0]     cyc_src, cyc_data;

  assign cyc_mask = (state_q == ST_IDLE) ? plan_m1 : m2_q;
  assign cyc_src  = (state_q == ST_IDLE) ? rot_now : rot_wdata_q;

  lane_gate #(.NLANES(NLANES)) u_wgate (
    .din (cyc_src),
    .keep(cyc_mask),
    .dout(cyc_data)
  );

  // read merge: first-cycle lanes from the buffer when split
  logic              in_second;
  logic [DW-1:0]     first_src, first_part, second_part, merged, rd_result;
  logic [NLANES-1:0] second_keep;

  assign in_second   = (state_q == ST_SECOND);
  assign first_src   = in_second ? lane_buf_q : bus_rdata;
  assign second_keep = m2_q & {NLANES{in_second}};

  lane_gate #(.NLANES(NLANES)) u_rgate_a (
    .din (first_src),
    .keep(m1_q),
    .dout(first_part)
  );

  lane_gate #(.NLANES(NLANES)) u_rgate_b (
    .din (bus_rdata),
    .keep(second_keep),
    .dout(second_part)
  );

  assign merged = first_part | second_part;

  byte_rotator #(.NLANES(NLANES), .LEFT(1'b0)) u_rrot (
    .din (merged),
    .amt (off_q),
    .dout(rd_result)
  );

  logic last_beat;
  assign last_beat = bus_ready &&
                     (((state_q == ST_FIRST) && !split_q) || in_second);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      write_q     <= 1'b0;
      off_q       <= '0;
      m1_q        <= '0;
      m2_q        <= '0;
      split_q     <= 1'b0;
      rot_wdata_q <= '0;
      lane_buf_q  <= '0;
      bus_valid_q <= 1'b0;
      bus_write_q <= 1'b0;
      bus_addr_q  <= '0;
      bus_be_n_q  <= '1;
      bus_wdata_q <= '0;
      done_q      <= 1'b0;
      fault_q     <= 1'b0;
      rdata_q     <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid) begin
            if (align_chk_en && plan_misal) begin
              fault_q <= 1'b1;
            end else begin
              write_q     <= req_write;
              off_q       <= req_off;
              m1_q        <= plan_m1;
              m2_q        <= plan_m2;
              split_q     <= plan_cross;
              rot_wdata_q <= rot_now;
              bus_valid_q <= 1'b1;
              bus_write_q <= req_write;
              bus_addr_q  <= {req_addr[AW-1:OFFW], {OFFW{1'b0}}};
              bus_be_n_q  <= ~plan_m1;
              bus_wdata_q <= req_write ? cyc_data : '0;
              state_q     <= ST_FIRST;
            end
          end
        end
        ST_FIRST: begin
          if (bus_ready && split_q) begin
            lane_buf_q  <= bus_rdata;
            bus_addr_q  <= bus_addr_q + WORD_STEP;
            bus_be_n_q  <= ~m2_q;
            bus_wdata_q <= write_q ? cyc_data : '0;
            state_q     <= ST_SECOND;
          end
        end
        ST_SECOND: begin
        end
        default: state_q <= ST_IDLE;
      endcase
      if (last_beat) begin
        bus_valid_q <= 1'b0;
        bus_be_n_q  <= '1;
        bus_wdata_q <= '0;
        done_q      <= 1'b1;
        state_q     <= ST_IDLE;
        if (!write_q) rdata_q <= rd_result;
      end
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign align_fault = fault_q;
  assign rdata       = rdata_q;
  assign bus_valid   = bus_valid_q;
  assign bus_write   = bus_write_q;
  assign bus_addr    = bus_addr_q;
  assign bus_be_n    = bus_be_n_q;
  assign bus_wdata   = bus_wdata_q;
endmodule

// File: rtl/dwbus_checker.sv
module dwbus_checker #(
  parameter int AW     = 32,
  parameter int NLANES = 4,
  localparam int OFFW = $clog2(NLANES),
  localparam int SZW  = $clog2(OFFW + 1),
  localparam int DW   = 8 * NLANES
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [SZW-1:0]    req_size,
  input logic              busy,
  input logic              done,
  input logic              align_fault,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [AW-1:0]     bus_addr,
  input logic [NLANES-1:0] bus_be_n,
  input logic [DW-1:0]     bus_wdata,
  input logic              bus_ready
);
  logic [DW-1:0] quiet_bits;
  for (genvar j = 0; j < NLANES; j++) begin : g_q
    assign quiet_bits[8*j +: 8] = {8{bus_be_n[j]}};
  end

  p_bus_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_addr[OFFW-1:0] == '0));

  p_enable_present_r2: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_be_n != '1));

  p_size_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |-> (32'(req_size) <= OFFW));

  p_next_word_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_ready) |=> (!bus_valid || (bus_addr == $past(bus_addr) + AW'(NLANES))));

  p_quiet_lanes_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_write) |-> ((bus_wdata & quiet_bits) == '0));

  p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) &&
                                   $stable(bus_be_n) && $stable(bus_wdata)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_fault_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (!bus_valid && !done && !busy));

  p_idle_enables_r9: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (bus_be_n == '1));

  p_busy_covers_bus_r10: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> busy);
endmodule

bind lane_split_unit dwbus_checker #(.AW(AW), .NLANES(NLANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_size   (req_size),
  .busy       (busy),
  .done       (done),
  .align_fault(align_fault),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_be_n   (bus_be_n),
  .bus_wdata  (bus_wdata),
  .bus_ready  (bus_ready)
);

// File: tb/tb_lane_split_unit.sv
module tb_lane_split_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, align_chk_en = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        busy, done, align_fault;
  logic [31:0] rdata;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_be_n;
  logic [31:0] bus_rdata = 32'h5A5A5A5A;
  logic        bus_ready = 1'b0;

  int total = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_split_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .align_chk_en(align_chk_en), .busy(busy), .done(done),
    .align_fault(align_fault), .rdata(rdata), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] addr;
    logic [31:0] wd;
    logic        chk;
    logic [3:0]  be1;
    logic [3:0]  be2;
    logic        flt;
    logic [1:0]  waits;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd2, 32'h100, 32'h0,        1'b0, 4'h0, 4'hF, 1'b0, 2'd0},
    '{1'b0, 2'd2, 32'h101, 32'h0,        1'b0, 4'h1, 4'hE, 1'b0, 2'd0},
    '{1'b1, 2'd2, 32'h101, 32'hAABBCCDD, 1'b0, 4'h1, 4'hE, 1'b0, 2'd1},
    '{1'b0, 2'd0, 32'h103, 32'h0,        1'b0, 4'h7, 4'hF, 1'b0, 2'd0},
    '{1'b1, 2'd0, 32'h100, 32'h000000E7, 1'b0, 4'hE, 4'hF, 1'b0, 2'd0},
    '{1'b0, 2'd1, 32'h103, 32'h0,        1'b0, 4'h7, 4'hE, 1'b0, 2'd0},
    '{1'b1, 2'd1, 32'h102, 32'h00001234, 1'b0, 4'h3, 4'hF, 1'b0, 2'd0},
    '{1'b0, 2'd1, 32'h101, 32'h0,        1'b0, 4'h9, 4'hF, 1'b0, 2'd1},
    '{1'b1, 2'd2, 32'h203, 32'h01020304, 1'b0, 4'h7, 4'h8, 1'b0, 2'd2},
    '{1'b0, 2'd2, 32'h102, 32'h0,        1'b0, 4'h3, 4'hC, 1'b0, 2'd1},
    '{1'b0, 2'd2, 32'h101, 32'h0,        1'b1, 4'hF, 4'hF, 1'b1, 2'd0},
    '{1'b1, 2'd1, 32'h101, 32'h0000BEEF, 1'b1, 4'hF, 4'hF, 1'b1, 2'd0},
    '{1'b0, 2'd1, 32'h102, 32'h0,        1'b1, 4'h3, 4'hF, 1'b0, 2'd0},
    '{1'b1, 2'd0, 32'h203, 32'h00000099, 1'b1, 4'h7, 4'hF, 1'b0, 2'd0},
    '{1'b0, 2'd2, 32'h1FC, 32'h0,        1'b1, 4'h0, 4'hF, 1'b0, 2'd0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return 32'hDEADBEEF ^ {4{a[9:2]}};
  endfunction

  // R5: byte k of store data on lane (off+k) mod 4, zero on disabled lanes
  function automatic logic [31:0] exp_lanes(input logic [31:0] wd,
                                            input logic [1:0] off,
                                            input logic [3:0] be_n);
    logic [31:0] r = '0;
    for (int j = 0; j < 4; j++) begin
      logic [1:0] k = 2'(j) - off;
      if (!be_n[j]) r[8*j +: 8] = wd[8*k +: 8];
    end
    return r;
  endfunction

  // R6: byte k from lane (off+k) mod 4 of the word that holds it
  function automatic logic [31:0] exp_read(input logic [31:0] addr,
                                           input logic [1:0] sz);
    logic [31:0] base = {addr[31:2], 2'b00};
    logic [31:0] r = '0;
    int n = 1 << sz;
    for (int k = 0; k < 4; k++) begin
      if (k < n) begin
        int p = int'(addr[1:0]) + k;
        logic [31:0] w = (p >= 4) ? mem_word(base + 32'd4) : mem_word(base);
        r[8*k +: 8] = w[8*(p % 4) +: 8];
      end
    end
    return r;
  endfunction

  task automatic run_vec(input vec_t v);
    logic [31:0] base = {v.addr[31:2], 2'b00};
    int ncyc = (v.be2 != 4'hF) ? 2 : 1;
    @(negedge clk);
    req_valid = 1'b1; req_write = v.wr; req_size = v.sz;
    req_addr = v.addr; req_wdata = v.wd; align_chk_en = v.chk;
    @(negedge clk);
    req_valid = 1'b0;
    if (v.flt) begin
      check(align_fault === 1'b1, "R8 fault raised", 32'(align_fault), 32'd1);
      check(bus_valid === 1'b0, "R8 no bus cycle", 32'(bus_valid), 32'd0);
      @(negedge clk);
      check(align_fault === 1'b0 && done === 1'b0 && bus_valid === 1'b0,
            "R8 fault one cycle, no done", {align_fault, done, bus_valid}, 32'd0);
      return;
    end
    check(align_fault === 1'b0, "R8 no fault on legal access", 32'(align_fault), 32'd0);
    for (int c = 0; c < ncyc; c++) begin
      logic [31:0] ea = base + 32'(4 * c);
      logic [3:0]  eb = (c == 0) ? v.be1 : v.be2;
      check(bus_valid === 1'b1 && bus_write === v.wr, "R4 bus cycle open",
            {bus_valid, bus_write}, {1'b1, v.wr});
      check(bus_addr === ea, "R1 aligned address", bus_addr, ea);
      check(bus_be_n === eb, "R2 R3 R4 lane enables", 32'(bus_be_n), 32'(eb));
      if (v.wr)
        check(bus_wdata === exp_lanes(v.wd, v.addr[1:0], eb), "R5 store lanes",
              bus_wdata, exp_lanes(v.wd, v.addr[1:0], eb));
      for (int w = 0; w < int'(v.waits); w++) begin
        @(negedge clk);
        check(bus_valid === 1'b1 && bus_addr === ea && bus_be_n === eb && done === 1'b0,
              "R7 hold without ready", bus_addr, ea);
      end
      bus_ready = 1'b1;
      bus_rdata = mem_word(ea);
      @(negedge clk);
      bus_ready = 1'b0;
      bus_rdata = 32'h5A5A5A5A;
      if (c < ncyc - 1)
        check(done === 1'b0, "R7 no done after first split cycle", 32'(done), 32'd0);
    end
    check(done === 1'b1, "R7 done after final ready", 32'(done), 32'd1);
    check(bus_valid === 1'b0, "R7 bus idle at done", 32'(bus_valid), 32'd0);
    if (!v.wr)
      check(rdata === exp_read(v.addr, v.sz), "R6 merged read", rdata,
            exp_read(v.addr, v.sz));
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R7 done single pulse",
          {done, busy}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check(bus_valid === 1'b0 && busy === 1'b0 && done === 1'b0 && align_fault === 1'b0,
          "R9 reset outputs", {bus_valid, busy, done, align_fault}, 32'd0);
    check(bus_be_n === 4'hF, "R9 reset enables", 32'(bus_be_n), 32'hF);
    rst = 1'b0;
    @(negedge clk);
    check(bus_be_n === 4'hF && bus_valid === 1'b0, "R9 idle after reset",
          32'(bus_be_n), 32'hF);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: a request raised while busy is dropped
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0;
    req_addr = 32'h100; req_wdata = 32'h11; align_chk_en = 1'b0;
    @(negedge clk);
    req_addr = 32'h300; req_size = 2'd2;
    check(busy === 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    check(bus_addr === 32'h100 && bus_be_n === 4'hE, "R10 busy request ignored",
          bus_addr, 32'h100);
    bus_ready = 1'b1;
    @(negedge clk);
    bus_ready = 1'b0;
    check(done === 1'b1, "R10 original access completes", 32'(done), 32'd1);
    @(negedge clk);
    check(bus_valid === 1'b0 && busy === 1'b0, "R10 dropped request not started",
          {bus_valid, busy}, 32'd0);

    // R8: misaligned access performed when checking is off
    run_vec('{1'b0, 2'd1, 32'h305, 32'h0, 1'b0, 4'h9, 4'hF, 1'b0, 2'd0});

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule